// File: doc/BRIEF.md
# Serial-Bus Controlled 8-bit Port Expander

This block is an I2C target that puts eight quasi-bidirectional port pins behind a single register. The controller opens a transfer with a START condition and sends a 7-bit address. The upper four bits of that address are a fixed parameter and the lower three come from strap inputs. The block acknowledges only its own address. After that, every data byte goes straight to the port, because there is no register pointer. A write loads the output latch, and a read returns the sampled pin levels.

Each pin is modelled by its latch bit plus two enables. A latch bit of 0 turns on a strong pull to ground. A latch bit of 1 leaves only a weak pull-up, so the pin can then be read as an input. The block keeps a stored copy of the pin levels. An active-low, open-drain interrupt enable stays on while the pins differ from that copy, so the controller learns of input changes without polling. The bus lines and the pins are brought into the system clock through two flip-flops, and the bus edges are detected from the synchronised samples. The block runs at standard-mode rates.

Top module: `i2c_port_expander`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {FIXED_ADDR, strap_i}. The default FIXED_ADDR is 4'b0100. It acknowledges by pulling SDA low for the ninth clock. Any other address gets no acknowledge, and the block ignores the rest of that transfer.
- R2: Bit 0 of the address byte sets the direction: 0 is a write to the port and 1 is a read from it.
- R3: During a write, the block acknowledges every data byte. The output latch takes that byte when SCL falls at the end of its acknowledge clock. Any number of bytes may follow in one transfer, and the last one wins.
- R4: During a read, each byte goes out MSB first. The value sent is the pin levels sampled at the rising SCL edge of the acknowledge clock just before that byte: the address acknowledge for the first byte, and the controller's acknowledge for each byte after it.
- R5: A controller NACK ends a read. SDA then stays released until the next START.
- R6: After reset the output latch is 8'hFF, all pins are weak-high inputs, and SDA and the interrupt are released.
- R7: pin_pull_low_o is the bitwise inverse of the output latch, and pin_weak_high_o equals the output latch.
- R8: irq_pull_o is 1 while the synchronised pin levels differ from the stored copy. It clears if the pins return to the stored value.
- R9: The stored copy takes the current pin levels at the acknowledge clock of every read byte and at the latch update of every written byte. This clears the interrupt.
- R10: A STOP at any point ends the transfer, releases SDA and leaves the latch unchanged if a byte was only partly sent. A START at any point, including a repeated START, begins a new address phase.
- R11: The block changes its SDA pull only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| sda_pull_o | output | 1 | 1 pulls the SDA line low |
| strap_i | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Levels seen on the port pins |
| port_latch_o | output | 8 | Output latch value |
| pin_pull_low_o | output | 8 | Per-pin strong pull-down enable |
| pin_weak_high_o | output | 8 | Per-pin weak pull-up enable |
| irq_pull_o | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
The assertions assume that SCL and SDA are well-formed bus waveforms. Each line is held for several system clocks, so the two-flop synchroniser sees every level, and a START or STOP never arrives while the block itself holds SDA low. They also assume that SCL stays low long enough after a falling edge for the block's delayed SDA update to land before SCL rises again. The bench drives the bus with quarter-bit phases of eight system clocks. It changes SDA only while SCL is low, except to form START and STOP, and it changes the pins only between bus phases. Under these conditions every timing assumption holds with several clocks of margin.

// File: rtl/i2c_port_expander.sv
module i2c_port_expander #(
  parameter logic [3:0] FIXED_ADDR = 4'b0100,
  parameter int         SYNC       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic [7:0] pin_i,
  output logic [7:0] port_latch_o,
  output logic [7:0] pin_pull_low_o,
  output logic [7:0] pin_weak_high_o,
  output logic       irq_pull_o
);
  localparam int W = 8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  logic [SYNC-1:0]        scl_p, sda_p;
  logic [SYNC-1:0][W-1:0] pin_p;
  logic                   scl_q, sda_q;
  logic                   scl_s, sda_s;
  logic [W-1:0]           pin_s;
  logic                   scl_rise, scl_fall, start_det, stop_det;

  st_t          st;
  logic [3:0]   cnt;
  logic [W-1:0] sh, rd_sh, snap, latch;
  logic         rnw, mack;

  assign scl_s     = scl_p[SYNC-1];
  assign sda_s     = sda_p[SYNC-1];
  assign pin_s     = pin_p[SYNC-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      pin_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC-2:0], scl_i};
      sda_p <= {sda_p[SYNC-2:0], sda_i};
      pin_p <= {pin_p[SYNC-2:0], pin_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      rd_sh      <= '1;
      snap       <= '1;
      latch      <= '1;
      rnw        <= 1'b0;
      mack       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_det) begin
      st         <= S_ADDR;
      cnt        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      st         <= S_IDLE;
      sda_pull_o <= 1'b0;
    end else begin
      unique case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[W-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            if (sh[W-1:1] == {FIXED_ADDR, strap_i}) begin
              st         <= S_AACK;
              rnw        <= sh[0];
              sda_pull_o <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_AACK: begin
          if (scl_rise && rnw) rd_sh <= pin_s;
          if (scl_fall) begin
            cnt <= '0;
            if (rnw) begin
              st         <= S_RD;
              sda_pull_o <= ~rd_sh[W-1];
            end else begin
              st         <= S_WR;
              sda_pull_o <= 1'b0;
            end
          end
        end
        S_WR: begin
          if (scl_rise) begin
            sh  <= {sh[W-2:0], sda_s};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            st         <= S_WACK;
            sda_pull_o <= 1'b1;
          end
        end
        S_WACK: begin
          if (scl_fall) begin
            latch      <= sh;
            snap       <= pin_s;
            st         <= S_WR;
            cnt        <= '0;
            sda_pull_o <= 1'b0;
          end
        end
        S_RD: begin
          if (scl_fall) begin
            rd_sh <= {rd_sh[W-2:0], 1'b0};
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              st         <= S_RACK;
              sda_pull_o <= 1'b0;
            end else begin
              sda_pull_o <= ~rd_sh[W-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
            snap <= pin_s;
            if (!sda_s) rd_sh <= pin_s;
          end else if (scl_fall) begin
            if (mack) begin
              st         <= S_RD;
              cnt        <= '0;
              sda_pull_o <= ~rd_sh[W-1];
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign port_latch_o    = latch;
  assign pin_pull_low_o  = ~latch;
  assign pin_weak_high_o = latch;
  assign irq_pull_o      = |(pin_s ^ snap);
endmodule

// File: rtl/i2c_port_expander_chk.sv
module i2c_port_expander_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_pull,
  input logic [7:0] pin_s,
  input logic       irq,
  input logic [7:0] latch,
  input logic       in_wack,
  input logic       in_idle,
  input logic       stop_det
);
  a_r11_sda_hold_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_s) |-> $stable(sda_pull));

  a_r8_irq_rise_on_pin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$stable(pin_s));

  a_r3_latch_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch) |-> $past(in_wack));

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull);
endmodule

bind i2c_port_expander i2c_port_expander_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_pull (sda_pull_o),
  .pin_s    (pin_s),
  .irq      (irq_pull_o),
  .latch    (port_latch_o),
  .in_wack  (st == S_WACK),
  .in_idle  (st == S_IDLE),
  .stop_det (stop_det)
);

// File: tb/test_i2c_port_expander.sv
module test_i2c_port_expander;
  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'd0;
  logic [7:0] pins = 8'hFF;
  logic       sda_pull, irq;
  logic [7:0] latch, pull_low, weak_high;
  wire        sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int r11_viol = 0;
  logic done = 1'b0;
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  always #4 clk = ~clk;

  i2c_port_expander i_i2c_port_expander (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(strap), .pin_i(pins),
    .port_latch_o(latch), .pin_pull_low_o(pull_low),
    .pin_weak_high_o(weak_high), .irq_pull_o(irq)
  );

  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_pull != prev_pull) r11_viol++;
    prev_scl  <= scl_m;
    prev_pull <= sda_pull;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b0; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    b = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    send_bit(~ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] exp_latch, d, p0, p1, p2, p3;

    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R6 reset state
    chk(latch == 8'hFF, "R6 latch", latch, 8'hFF);
    chk(weak_high == 8'hFF && pull_low == 8'h00, "R6 pins", {weak_high, pull_low}, 16'hFF00);
    chk(!sda_pull && !irq, "R6 released", {sda_pull, irq}, 0);
    exp_latch = 8'hFF;

    // R1 R3 R7: sweep every strap against every low address
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        strap = 3'(s);
        wq(4);
        d = 8'(s * 37 + a * 11 + 5);
        bus_start();
        write_byte({4'b0100, 3'(a), 1'b0}, ack);
        chk(ack == (s == a), "R1 address ack", ack, (s == a));
        write_byte(d, ack);
        if (s == a) begin
          chk(ack, "R3 data ack", ack, 1);
          exp_latch = d;
        end
        bus_stop();
        chk(latch == exp_latch, "R1 R3 latch", latch, exp_latch);
        chk(pull_low == ~exp_latch && weak_high == exp_latch, "R7 enables", pull_low, ~exp_latch);
      end
    end

    // R1 wrong fixed bits
    strap = 3'd5; wq(4);
    bus_start();
    write_byte({4'b0111, 3'd5, 1'b0}, ack);
    chk(!ack, "R1 wrong upper bits", ack, 0);
    write_byte(8'h00, ack);
    bus_stop();
    chk(latch == exp_latch, "R1 ignored", latch, exp_latch);

    // R3 multi-byte write, last wins
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b0}, ack);
    for (int k = 0; k < 3; k++) begin
      d = 8'(8'h3C ^ (k * 8'h99));
      write_byte(d, ack);
      chk(ack && latch == d, "R3 stream byte", latch, d);
    end
    bus_stop();

    // R2 R4 R5 read stream with pins changing between bytes
    for (int k = 0; k < 4; k++) begin
      p0 = 8'(8'hA5 + k * 8'h13);
      p1 = ~p0;
      p2 = 8'(p0 ^ 8'h0F);
      p3 = 8'(k * 8'h41);
      pins = p0; wq(4);
      bus_start();
      write_byte({4'b0100, 3'd5, 1'b1}, ack);
      chk(ack, "R2 read address ack", ack, 1);
      pins = p1;
      read_byte(1'b1, d);
      chk(d == p0, "R4 first byte", d, p0);
      pins = p2;
      read_byte(1'b1, d);
      chk(d == p1, "R4 second byte", d, p1);
      pins = p3;
      read_byte(1'b0, d);
      chk(d == p2, "R4 third byte", d, p2);
      read_byte(1'b0, d);
      chk(d == 8'hFF, "R5 released after nack", d, 8'hFF);
      bus_stop();
      chk(!irq, "R9 read recapture", irq, 0);
    end

    // R8 change and return
    pins = 8'h33; wq(2*Q);
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b1}, ack);
    read_byte(1'b0, d);
    bus_stop();
    chk(!irq, "R9 clear", irq, 0);
    pins = 8'h37; wq(6);
    chk(irq, "R8 assert", irq, 1);
    pins = 8'h33; wq(6);
    chk(!irq, "R8 return", irq, 0);

    // R9 write recapture
    pins = 8'h13; wq(6);
    chk(irq, "R8 assert again", irq, 1);
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b0}, ack);
    write_byte(8'h77, ack);
    chk(!irq, "R9 write recapture", irq, 0);
    bus_stop();
    exp_latch = 8'h77;

    // R10 stop inside a byte
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_stop();
    chk(latch == exp_latch, "R10 aborted byte", latch, exp_latch);
    chk(!sda_pull, "R10 sda released", sda_pull, 0);

    // R10 repeated start into a read
    pins = 8'hC6; wq(4);
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b0}, ack);
    write_byte(8'h5A, ack);
    bus_start();
    write_byte({4'b0100, 3'd5, 1'b1}, ack);
    chk(ack, "R10 repeated start ack", ack, 1);
    read_byte(1'b0, d);
    chk(d == 8'hC6, "R10 repeated start read", d, 8'hC6);
    bus_stop();
    chk(latch == 8'h5A, "R10 latch kept", latch, 8'h5A);

    chk(r11_viol == 0, "R11 sda while scl high", r11_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule